// File: doc/BRIEF.md
# Write-Through Store Queue with Read-Miss Hazard Check

This block sits between a write-through cache and the next memory level. It takes store requests from the processor, each an address and a data word, into a small queue of entries. The processor stalls on a store only when every entry is occupied. Entries are written to the lower level in arrival order over a valid/ready port, and one entry retires for each accepted transfer.

Read misses share the same lower-level port and take precedence over queued stores. Before a read is issued, its address is compared against every occupied entry. If no entry matches, the read goes out at once, ahead of any older stores. If an entry matches, the queue keeps draining in order until no matching entry remains, and only then is the read issued. Memory therefore never returns a value that a buffered store is about to overwrite. The cache controller sees full and empty flags.

Top module: `wt_store_queue`

## Requirements
- R1: While reset is asserted and on the first cycle after it, empty_o is 1, full_o is 0 and mem_valid_o is 0.
- R2: While fewer than DEPTH entries are occupied, st_ready_o is 1, so DEPTH stores in consecutive cycles are all accepted with no stall.
- R3: With DEPTH entries occupied and no write transfer completing in that cycle, st_ready_o is 0. A store offered then is not stored: it never appears on the memory port.
- R4: With no read request pending, or with a pending read that conflicts, an occupied queue drives mem_valid_o=1 and mem_we_o=1, with mem_addr_o and mem_wdata_o taken from the oldest entry. That entry retires on a cycle with mem_ready_i=1, so stores reach memory in the order they were accepted.
- R5: A read request (rd_valid_i=1) whose address matches no occupied entry drives mem_valid_o=1, mem_we_o=0 and mem_addr_o=rd_addr_i in the same cycle, ahead of any queued stores. rd_ready_o then equals mem_ready_i, and no entry retires in that cycle.
- R6: While a read request's address matches any occupied entry, no read is issued (rd_ready_o=0). Entries drain oldest first until no match remains, and then the read is issued as in R5.
- R7: With DEPTH entries occupied and a write transfer completing in the same cycle, st_ready_o is 1 and the offered store is accepted.
- R8: empty_o is 1 exactly when no entry is occupied, and full_o is 1 exactly when DEPTH entries are occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| st_valid_i | input | 1 | Store request from the processor |
| st_addr_i | input | AW | Store address |
| st_data_i | input | DW | Store data |
| st_ready_o | output | 1 | Store accepted in this cycle when st_valid_i is high |
| rd_valid_i | input | 1 | Read-miss request, held until granted |
| rd_addr_i | input | AW | Read-miss address |
| rd_ready_o | output | 1 | Read accepted by memory in this cycle |
| mem_valid_o | output | 1 | Lower-level request valid |
| mem_we_o | output | 1 | 1 for a write transfer, 0 for a read |
| mem_addr_o | output | AW | Lower-level address |
| mem_wdata_o | output | DW | Lower-level write data |
| mem_ready_i | input | 1 | Lower level accepts the request |
| full_o | output | 1 | All entries occupied |
| empty_o | output | 1 | No entry occupied |

## Verification
Two cycle-level coincidences matter here. The first is a store arriving in the same cycle that the memory port retires an entry from a full queue. The second is a read miss arriving while older stores wait, some of them to the same address. Directed sequences fill the queue with memory stalled, then offer a store together with a ready transfer, and issue a read to an address held in the middle of the queue. A seeded random phase then mixes stores, reads drawn from a small address pool and an irregular ready signal. Each cycle, a bench model of the queue predicts the port request, the store and read acceptance, and the flags, and the bench compares them against the outputs before the clock edge.

// File: rtl/wtsq_pkg.sv
package wtsq_pkg;
  typedef enum logic [1:0] {
    MEM_IDLE = 2'd0,
    MEM_RD   = 2'd1,
    MEM_WR   = 2'd2
  } mem_op_e;
endpackage

// File: rtl/wtsq_fifo.sv
module wtsq_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic [DEPTH-1:0] slot_vld_o,
  output logic [AW-1:0] slot_addr_o [DEPTH],
  output logic [CW-1:0] cnt_o
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      // pop before push so a push into the slot just freed wins
      if (pop_i) begin
        vld_q[rd_q] <= 1'b0;
        rd_q        <= ptr_inc(rd_q);
      end
      if (push_i) begin
        vld_q[wr_q] <= 1'b1;
        wr_q        <= ptr_inc(wr_q);
      end
      if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_q] <= push_addr_i;
      data_q[wr_q] <= push_data_i;
    end
  end

  assign head_addr_o = addr_q[rd_q];
  assign head_data_o = data_q[rd_q];
  assign slot_vld_o  = vld_q;
  assign slot_addr_o = addr_q;
  assign cnt_o       = cnt_q;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q < CW'(DEPTH)));
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
  p_cnt_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(cnt_q));
  p_vld_cnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> ($countones(vld_q) == int'(cnt_q)));
endmodule

// File: rtl/wtsq_match.sv
module wtsq_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic             rd_valid_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [DEPTH-1:0] slot_vld_i,
  input  logic [AW-1:0]    slot_addr_i [DEPTH],
  output logic             hazard_o
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = slot_vld_i[g] && (slot_addr_i[g] == rd_addr_i);
  end

  assign hazard_o = rd_valid_i && (|hit_vec);
endmodule

// File: rtl/wtsq_arb.sv
module wtsq_arb
  import wtsq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          hazard_i,
  input  logic          q_nonempty_i,
  input  logic [AW-1:0] head_addr_i,
  input  logic [DW-1:0] head_data_i,
  input  logic          mem_ready_i,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          rd_grant_o,
  output logic          pop_o
);
  mem_op_e op;

  always_comb begin
    if (rd_valid_i && !hazard_i) op = MEM_RD;
    else if (q_nonempty_i)       op = MEM_WR;
    else                         op = MEM_IDLE;
  end

  assign mem_valid_o = (op != MEM_IDLE);
  assign mem_we_o    = (op == MEM_WR);
  assign mem_addr_o  = (op == MEM_RD) ? rd_addr_i : head_addr_i;
  assign mem_wdata_o = head_data_i;
  assign rd_grant_o  = (op == MEM_RD) && mem_ready_i;
  assign pop_o       = (op == MEM_WR) && mem_ready_i;

  always_comb begin
    a_grant_excl_r5: assert (!(rd_grant_o && pop_o));
  end
endmodule

// File: rtl/wt_store_queue.sv
module wt_store_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  output logic          st_ready_o,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_ready_o,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  output logic          full_o,
  output logic          empty_o
);
  logic             push, pop, hazard;
  logic [AW-1:0]    head_addr;
  logic [DW-1:0]    head_data;
  logic [DEPTH-1:0] slot_vld;
  logic [AW-1:0]    slot_addr [DEPTH];
  logic [CW-1:0]    cnt;

  assign full_o     = (cnt == CW'(DEPTH));
  assign empty_o    = (cnt == '0);
  // a retiring entry frees a slot for a store in the same cycle
  assign st_ready_o = !full_o || pop;
  assign push       = st_valid_i && st_ready_o;

  wtsq_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_addr_i(st_addr_i), .push_data_i(st_data_i),
    .pop_i(pop),
    .head_addr_o(head_addr), .head_data_o(head_data),
    .slot_vld_o(slot_vld), .slot_addr_o(slot_addr), .cnt_o(cnt)
  );

  wtsq_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
    .rd_valid_i, .rd_addr_i,
    .slot_vld_i(slot_vld), .slot_addr_i(slot_addr),
    .hazard_o(hazard)
  );

  wtsq_arb #(.AW(AW), .DW(DW)) u_arb (
    .rd_valid_i, .rd_addr_i, .hazard_i(hazard),
    .q_nonempty_i(!empty_o),
    .head_addr_i(head_addr), .head_data_i(head_data),
    .mem_ready_i,
    .mem_valid_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .rd_grant_o(rd_ready_o), .pop_o(pop)
  );

  p_rd_no_stale_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_we_o) |-> !(|slot_vld) || !hazard);
  p_rd_prio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !hazard) |-> (mem_valid_o && !mem_we_o && !pop));
  p_full_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !(mem_valid_o && mem_we_o && mem_ready_i)) |-> !st_ready_o);
  p_idle_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !rd_valid_i) |-> !mem_valid_o);
  p_flags_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (empty_o && !full_o));
endmodule

// File: tb/wt_store_queue_bench.sv
module wt_store_queue_bench;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, rd_valid = 1'b0, mem_ready = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0, rd_addr = '0;
  logic        st_ready, rd_ready, mem_valid, mem_we, full, empty;
  logic [31:0] mem_addr, mem_wdata;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] qa [D];
  logic [31:0] qd [D];
  int qn = 0;

  always #4 clk = ~clk;

  wt_store_queue #(.DEPTH(D), .AW(32), .DW(32)) u_wt_store_queue (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data),
    .st_ready_o(st_ready),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_ready_o(rd_ready),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .full_o(full), .empty_o(empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model_hit(input logic [31:0] a);
    for (int i = 0; i < qn; i++) if (qa[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  // one cycle: drive, predict, compare, update model
  task automatic step(input logic sv, input logic [31:0] sa, input logic [31:0] sd,
                      input logic rv, input logic [31:0] ra, input logic mr,
                      output logic granted);
    bit hit, e_valid, e_we, e_pop, e_str;
    string wr_tag;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd;
    rd_valid = rv; rd_addr = ra; mem_ready = mr;
    #1;
    hit     = rv && model_hit(ra);
    e_valid = (rv && !hit) || (qn > 0);
    e_we    = !(rv && !hit);
    e_pop   = e_valid && e_we && mr;
    e_str   = (qn < D) || e_pop;
    wr_tag  = (rv && hit) ? "R6" : "R4";
    chk("R5/R4 mem_valid", {31'd0, mem_valid}, {31'd0, e_valid});
    if (e_valid) begin
      if (!e_we) begin
        chk("R5 read we", {31'd0, mem_we}, 32'd0);
        chk("R5 read addr", mem_addr, ra);
      end else begin
        chk({wr_tag, " write we"}, {31'd0, mem_we}, 32'd1);
        chk({wr_tag, " write addr"}, mem_addr, qa[0]);
        chk({wr_tag, " write data"}, mem_wdata, qd[0]);
      end
    end
    chk(rv && hit ? "R6 rd_ready" : "R5 rd_ready", {31'd0, rd_ready},
        {31'd0, rv && !hit && mr});
    chk(qn < D ? "R2 st_ready" : (e_pop ? "R7 st_ready" : "R3 st_ready"),
        {31'd0, st_ready}, {31'd0, e_str});
    chk("R8 full", {31'd0, full}, {31'd0, qn == D});
    chk("R8 empty", {31'd0, empty}, {31'd0, qn == 0});
    granted = rv && !hit && mr;
    if (e_pop) begin
      for (int i = 0; i < D - 1; i++) begin qa[i] = qa[i+1]; qd[i] = qd[i+1]; end
      qn--;
    end
    if (sv && e_str) begin qa[qn] = sa; qd[qn] = sd; qn++; end
  endtask

  function automatic logic [31:0] pool_addr();
    return 32'h0000_0100 + 32'(($urandom % 6) * 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic g;
    logic [31:0] target;
    void'($urandom(32'h0005_1ee7));
    repeat (3) @(negedge clk);
    chk("R1 empty in reset", {31'd0, empty}, 32'd1);
    chk("R1 full in reset", {31'd0, full}, 32'd0);
    chk("R1 mem_valid in reset", {31'd0, mem_valid}, 32'd0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, g);
    chk("R1 mem_valid after reset", {31'd0, mem_valid}, 32'd0);

    // R2: burst of DEPTH stores with memory stalled
    for (int i = 0; i < D; i++) step(1, 32'h200 + 32'(i*4), 32'hA000 + 32'(i), 0, 0, 0, g);
    // R3: extra store while full and stalled is refused
    step(1, 32'h3FC, 32'hDEAD, 0, 0, 0, g);
    step(0, 0, 0, 0, 0, 0, g);
    // R7: full with a completing drain accepts a store
    step(1, 32'h300, 32'hB007, 0, 0, 1, g);
    chk("R7 still full", {31'd0, full}, 32'd1);
    // R5: non-conflicting read goes ahead of full queue
    step(0, 0, 0, 1, 32'h500, 1, g);
    chk("R5 read granted", {31'd0, g}, 32'd1);
    // R6: read to a mid-queue address drains until no match
    target = 32'h20C;
    g = 0;
    for (int i = 0; i < 12 && !g; i++) step(0, 0, 0, 1, target, 1, g);
    chk("R6 read eventually granted", {31'd0, g}, 32'd1);
    // drain remainder in order
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 1, g);
    chk("R8 empty after drain", {31'd0, empty}, 32'd1);

    // random mix
    begin
      logic rv_p = 0;
      logic [31:0] ra_p = 0;
      for (int n = 0; n < 4000; n++) begin
        if (!rv_p && ($urandom % 4 == 0)) begin
          rv_p = 1;
          ra_p = (qn > 0 && $urandom % 2 == 1) ? qa[$urandom % qn] : pool_addr();
        end
        step($urandom % 2 == 1, pool_addr(), $urandom, rv_p, ra_p, $urandom % 3 != 0, g);
        if (g) rv_p = 0;
      end
    end
    for (int i = 0; i < D + 2; i++) step(0, 0, 0, 0, 0, 1, g);
    chk("R8 empty at end", {31'd0, empty}, 32'd1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule